// File: doc/BRIEF.md
# FIFO Trigger and Receive Timeout Controller

This block sits between a serial port's shifters and its host-side register interface. It holds one receive FIFO and one transmit FIFO, both plain circular buffers. It turns their fill levels into a receive request and a transmit request, measured against programmable trigger thresholds. The thresholds are scaled by a factor that depends on which channel the block is built for. When the FIFOs are disabled, each direction falls back to a single holding register.

A small timer watches the receive side for idle periods. It is counted in whole character times, and a word-time tick input supplies one pulse per character. The timer is armed by received bytes and halted once the trigger threshold is reached. On expiry it can raise a sticky timeout status, which feeds the receive request until software clears it. A receive-DMA busy line tells a DMA engine when there is nothing to fetch.

The timer is a two-state machine, `TMR_IDLE` and `TMR_RUN`, with four transitions:
- **arm** (`TMR_IDLE` to `TMR_RUN`): a byte arrives while the timer is allowed and the threshold is not yet reached; the counter loads the character count.
- **reload** (`TMR_RUN` to `TMR_RUN`): a further byte arrives; the counter loads the character count again.
- **halt** (`TMR_RUN` to `TMR_IDLE`): the threshold is reached, the timer is disabled or the FIFO is disabled.
- **expire** (`TMR_RUN` to `TMR_IDLE`): the last tick of the count arrives.

Top module: `ftt_ctrl`

## Requirements
- R1: The configuration word is written with `cfg_we`. Its fields are: bit 0 enables the FIFOs, bit 1 empties the receive FIFO, bit 2 empties the transmit FIFO, bits [5:3] hold the receive trigger field and bits [8:6] hold the transmit trigger field. The two empty bits act on the writing clock edge and always read back as 0 on `cfg_rdata`; the other fields read back as written.
- R2: The channel factor is 32 for CHANNEL 0, 8 for CHANNEL 1 and 4, 2 for CHANNEL 2 and 3, and 0 otherwise. The transmit level is the transmit field times the factor. The receive level is the receive field plus one, times the factor.
- R3: With the FIFOs enabled, `tx_req` is high exactly when `tx_count` is at or below the transmit level. With them disabled, `tx_req` is high exactly when the transmit holding register is empty.
- R4: With the FIFOs enabled, `rx_req` is high when any of these holds: `rx_count` is at or above the receive level; `rx_count` is nonzero while `tmo_en` is low; the timeout status is set.
- R5: Each FIFO returns bytes in arrival order. It holds up to DEPTH bytes. A push into a full FIFO is dropped, and a pop from an empty FIFO changes nothing and shows 0 on its data output. A FIFO empty command takes priority over a push in the same cycle.
- R6: With the FIFOs disabled, each direction holds one byte and pushes into an occupied holding register are ignored. `rx_req` is then high when a received byte is waiting or the timeout status is set.
- R7: When a byte is pushed with the FIFOs enabled, `tmo_en` high and the receive level not reached, the timer is armed or restarted with `tmo_chars` character times. It expires on the `tmo_chars`-th following tick; a count of 0 or 1 expires on the first tick.
- R8: The timer halts, and cannot expire until it is armed again, when the receive level is reached, when `tmo_en` is low or when the FIFOs are disabled.
- R9: On expiry, the timeout status `rx_timeout` is set if the receive FIFO holds data or `tmo_force` is high. Otherwise expiry has no effect.
- R10: A `tmo_clr` pulse clears `rx_timeout`. If an expiry sets the status in the same cycle, the set wins.
- R11: `dma_busy` is high exactly when `rx_mode` equals 2 and the receive side holds no byte.
- R12: After reset, both FIFOs are empty, the configuration word is 0, the timer is idle and `rx_timeout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 9 | Configuration write value |
| cfg_rdata | output | 9 | Configuration readback |
| rx_mode | input | 2 | Receive service mode; 2 selects DMA |
| tmo_en | input | 1 | Receive timeout enable |
| tmo_force | input | 1 | Lets the timeout set the status with the FIFO empty |
| tmo_chars | input | 4 | Timeout length in character times |
| word_tick | input | 1 | One pulse per character time |
| rx_push | input | 1 | Received byte strobe |
| rx_din | input | DATA_W | Received byte |
| rx_pop | input | 1 | Host read of the receive side |
| rx_dout | output | DATA_W | Oldest received byte |
| rx_count | output | clog2(DEPTH)+1 | Receive occupancy |
| tx_push | input | 1 | Host write to the transmit side |
| tx_din | input | DATA_W | Byte to transmit |
| tx_pop | input | 1 | Shifter takes a byte |
| tx_dout | output | DATA_W | Oldest byte to transmit |
| tx_count | output | clog2(DEPTH)+1 | Transmit occupancy |
| tmo_clr | input | 1 | Clears the timeout status |
| rx_timeout | output | 1 | Sticky receive timeout status |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| dma_busy | output | 1 | Receive DMA has nothing to fetch |

## Verification
The bench builds the block with DEPTH 16 and CHANNEL 2, so the factor is 2. This gives a receive level of 4 from field 1 and a transmit level of 4 from field 2. Both thresholds, their off-by-one neighbours and the full-FIFO drop are then reached within a few pushes. Short timeout counts of 0, 1 and 3 character times cover every timer transition: arm, reload, halt by level, halt by disable, and expire. Expiry is exercised with and without data present, with and without the force input, and coinciding with a clear.

// File: rtl/ftt_pkg.sv
package ftt_pkg;

    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic [2:0] tx_trig;
        logic [2:0] rx_trig;
        logic       tx_flush;
        logic       rx_flush;
        logic       enable;
    } fifo_cfg_t;

    localparam int CFG_W = $bits(fifo_cfg_t);

    function automatic int unsigned chan_factor(input int unsigned ch);
        case (ch)
            0:       return 32;
            1, 4:    return 8;
            2, 3:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ftt_fifo.sv
module ftt_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              single,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count
);

    localparam logic [PTR_W-1:0] LAST    = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              full, empty, do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = single ? !empty : (count == DEPTH_C);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ftt_thresh.sv
module ftt_thresh #(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 5,
    parameter int LVL_W   = 9
) (
    input  logic             fifo_en,
    input  logic [2:0]       rx_trig,
    input  logic [2:0]       tx_trig,
    input  logic             tmo_en,
    input  logic             tmo_status,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    output logic             rx_lvl_hit,
    output logic             rx_req,
    output logic             tx_req
);

    import ftt_pkg::*;

    localparam int unsigned FACTOR = chan_factor(CHANNEL);
    localparam logic [LVL_W-1:0] FACT_C = LVL_W'(FACTOR);

    logic [LVL_W-1:0] rx_lvl, tx_lvl, rx_cnt_x, tx_cnt_x;

    assign tx_lvl   = LVL_W'(tx_trig) * FACT_C;
    assign rx_lvl   = (LVL_W'(rx_trig) + 1'b1) * FACT_C;
    assign rx_cnt_x = LVL_W'(rx_count);
    assign tx_cnt_x = LVL_W'(tx_count);

    assign rx_lvl_hit = fifo_en && (rx_cnt_x >= rx_lvl);

    always_comb begin
        if (fifo_en) begin
            rx_req = rx_lvl_hit || ((rx_count != '0) && !tmo_en) || tmo_status;
            tx_req = (tx_cnt_x <= tx_lvl);
        end else begin
            rx_req = (rx_count != '0) || tmo_status;
            tx_req = (tx_count == '0);
        end
    end

endmodule

// File: rtl/ftt_rx_timer.sv
module ftt_rx_timer #(
    parameter int TMO_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_ok,
    input  logic             rx_push,
    input  logic             lvl_hit,
    input  logic             word_tick,
    input  logic [TMO_W-1:0] chars,
    input  logic             has_data,
    input  logic             force_set,
    input  logic             clr,
    output logic             tmo_status,
    output logic             running
);

    import ftt_pkg::*;

    tmr_state_e       state, nxt;
    logic [TMO_W-1:0] cnt;
    logic             load, dec, fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TMR_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        dec  = 1'b0;
        fire = 1'b0;
        unique case (state)
            TMR_IDLE: begin
                if (rx_push && arm_ok && !lvl_hit) begin
                    nxt  = TMR_RUN;
                    load = 1'b1;
                end
            end
            TMR_RUN: begin
                if (!arm_ok || lvl_hit) begin
                    nxt = TMR_IDLE;
                end else if (rx_push) begin
                    load = 1'b1;
                end else if (word_tick) begin
                    if (cnt <= TMO_W'(1)) begin
                        fire = 1'b1;
                        nxt  = TMR_IDLE;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            default: nxt = TMR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            tmo_status <= 1'b0;
        end else begin
            if (load) begin
                cnt <= chars;
            end else if (dec) begin
                cnt <= cnt - 1'b1;
            end
            if (fire && (has_data || force_set)) begin
                tmo_status <= 1'b1;
            end else if (clr) begin
                tmo_status <= 1'b0;
            end
        end
    end

    assign running = (state == TMR_RUN);

endmodule

// File: rtl/ftt_ctrl.sv
module ftt_ctrl #(
    parameter int DEPTH   = 16,
    parameter int CHANNEL = 0,
    parameter int DATA_W  = 8,
    parameter int TMO_W   = 4,
    localparam int CNT_W  = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [8:0]           cfg_wdata,
    output logic [8:0]           cfg_rdata,
    input  logic [1:0]           rx_mode,
    input  logic                 tmo_en,
    input  logic                 tmo_force,
    input  logic [TMO_W-1:0]     tmo_chars,
    input  logic                 word_tick,
    input  logic                 rx_push,
    input  logic [DATA_W-1:0]    rx_din,
    input  logic                 rx_pop,
    output logic [DATA_W-1:0]    rx_dout,
    output logic [CNT_W-1:0]     rx_count,
    input  logic                 tx_push,
    input  logic [DATA_W-1:0]    tx_din,
    input  logic                 tx_pop,
    output logic [DATA_W-1:0]    tx_dout,
    output logic [CNT_W-1:0]     tx_count,
    input  logic                 tmo_clr,
    output logic                 rx_timeout,
    output logic                 rx_req,
    output logic                 tx_req,
    output logic                 dma_busy
);

    import ftt_pkg::*;

    localparam int LVL_W = (CNT_W > 9) ? CNT_W : 9;
    localparam logic [1:0] MODE_DMA = 2'd2;

    fifo_cfg_t cfg_w, cfg_q;
    logic      rx_flush, tx_flush, rx_lvl_hit, tmr_run;

    assign cfg_w     = fifo_cfg_t'(cfg_wdata);
    assign rx_flush  = cfg_we && cfg_w.rx_flush;
    assign tx_flush  = cfg_we && cfg_w.tx_flush;
    assign cfg_rdata = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= '{tx_trig:  cfg_w.tx_trig,
                       rx_trig:  cfg_w.rx_trig,
                       tx_flush: 1'b0,
                       rx_flush: 1'b0,
                       enable:   cfg_w.enable};
        end
    end

    ftt_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!cfg_q.enable),
        .push(rx_push), .din(rx_din), .pop(rx_pop),
        .dout(rx_dout), .count(rx_count)
    );

    ftt_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(!cfg_q.enable),
        .push(tx_push), .din(tx_din), .pop(tx_pop),
        .dout(tx_dout), .count(tx_count)
    );

    ftt_thresh #(.CHANNEL(CHANNEL), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_thresh (
        .fifo_en(cfg_q.enable), .rx_trig(cfg_q.rx_trig), .tx_trig(cfg_q.tx_trig),
        .tmo_en(tmo_en), .tmo_status(rx_timeout),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_lvl_hit(rx_lvl_hit), .rx_req(rx_req), .tx_req(tx_req)
    );

    ftt_rx_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .arm_ok(cfg_q.enable && tmo_en), .rx_push(rx_push),
        .lvl_hit(rx_lvl_hit), .word_tick(word_tick), .chars(tmo_chars),
        .has_data(rx_count != '0), .force_set(tmo_force), .clr(tmo_clr),
        .tmo_status(rx_timeout), .running(tmr_run)
    );

    assign dma_busy = (rx_mode == MODE_DMA) && (rx_count == '0);

endmodule

// File: rtl/ftt_checker.sv
module ftt_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [8:0]       cfg_wdata,
    input logic             fifo_en,
    input logic             rx_push,
    input logic             rx_pop,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_req,
    input logic             word_tick,
    input logic             tmo_clr,
    input logic             rx_timeout,
    input logic             dma_busy,
    input logic             lvl_hit,
    input logic             tmr_run
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= DEPTH_C) && (tx_count <= DEPTH_C));

    p_flush_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[1]) |=> (rx_count == '0));

    p_flush_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[2]) |=> (tx_count == '0));

    p_push_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_push && !rx_pop && (rx_count < DEPTH_C) && !(cfg_we && cfg_wdata[1]))
        |=> (rx_count == CNT_W'($past(rx_count) + 1'b1)));

    p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && (rx_count != '0) && rx_push && !rx_pop && !(cfg_we && cfg_wdata[1]))
        |=> (rx_count == $past(rx_count)));

    p_tx_req_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && (tx_count == '0)) |-> tx_req);

    p_tx_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && (tx_count != '0)) |-> !tx_req);

    p_timer_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_hit |=> !tmr_run);

    p_tmo_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_timeout) |-> $past(word_tick));

    p_tmo_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_clr && !word_tick) |=> !rx_timeout);

    p_dma_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> (rx_count == '0));

endmodule

bind ftt_ctrl ftt_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .fifo_en(cfg_q.enable), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_count(rx_count), .tx_count(tx_count), .tx_req(tx_req),
    .word_tick(word_tick), .tmo_clr(tmo_clr), .rx_timeout(rx_timeout),
    .dma_busy(dma_busy), .lvl_hit(rx_lvl_hit), .tmr_run(tmr_run)
);

// File: tb/test_ftt_ctrl.sv
module test_ftt_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic [8:0] cfg_rdata;
    logic [1:0] rx_mode = 2'd0;
    logic       tmo_en = 1'b1;
    logic       tmo_force = 1'b0;
    logic [3:0] tmo_chars = 4'd3;
    logic       word_tick = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_din = '0, tx_din = '0, rx_dout, tx_dout;
    logic [4:0] rx_count, tx_count;
    logic       tmo_clr = 1'b0;
    logic       rx_timeout, rx_req, tx_req, dma_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ftt_ctrl #(.DEPTH(16), .CHANNEL(2), .DATA_W(8), .TMO_W(4)) i_ftt_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_mode(rx_mode), .tmo_en(tmo_en),
        .tmo_force(tmo_force), .tmo_chars(tmo_chars), .word_tick(word_tick),
        .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_dout(rx_dout),
        .rx_count(rx_count), .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop),
        .tx_dout(tx_dout), .tx_count(tx_count), .tmo_clr(tmo_clr),
        .rx_timeout(rx_timeout), .rx_req(rx_req), .tx_req(tx_req),
        .dma_busy(dma_busy)
    );

    typedef struct packed {
        logic       we;
        logic [8:0] wd;
        logic       rxp;
        logic       rxo;
        logic       txp;
        logic       txo;
        logic [7:0] d;
        logic [4:0] erx;
        logic [4:0] etx;
        logic       erq;
        logic       etq;
    } vec_t;

    // cfg 0x08F: enable, empty both, rx field 1 (level 4), tx field 2 (level 4)
    localparam vec_t TBL [14] = '{
        '{1'b1, 9'h08F, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd0, 5'd0, 1'b0, 1'b1}, // R1
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA1, 5'd1, 5'd0, 1'b0, 1'b1}, // R4
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA2, 5'd2, 5'd0, 1'b0, 1'b1},
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA3, 5'd3, 5'd0, 1'b0, 1'b1}, // R2 below rx level
        '{1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA4, 5'd4, 5'd0, 1'b1, 1'b1}, // R2 rx level
        '{1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB1, 5'd4, 5'd1, 1'b1, 1'b1}, // R3
        '{1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB2, 5'd4, 5'd2, 1'b1, 1'b1},
        '{1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB3, 5'd4, 5'd3, 1'b1, 1'b1},
        '{1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB4, 5'd4, 5'd4, 1'b1, 1'b1}, // R2 tx level
        '{1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB5, 5'd4, 5'd5, 1'b1, 1'b0}, // R3 above
        '{1'b0, 9'h000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 5'd3, 5'd5, 1'b0, 1'b0}, // R5 pop
        '{1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 5'd3, 5'd4, 1'b0, 1'b1},
        '{1'b1, 9'h08B, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd0, 5'd4, 1'b0, 1'b1}, // R1 rx empty
        '{1'b1, 9'h08D, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 5'd0, 5'd0, 1'b0, 1'b1}  // R1 tx empty
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [8:0] wd, input logic rxp,
                       input logic rxo, input logic txp, input logic txo,
                       input logic [7:0] d, input logic tk, input logic clr);
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd; rx_push = rxp; rx_pop = rxo;
        tx_push = txp; tx_pop = txo; rx_din = d; tx_din = d;
        word_tick = tk; tmo_clr = clr;
        @(posedge clk);
        #2;
        cfg_we = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; tx_push = 1'b0;
        tx_pop = 1'b0; word_tick = 1'b0; tmo_clr = 1'b0;
    endtask

    task automatic idle();        cyc(1'b0, 9'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0); endtask
    task automatic rxp(input logic [7:0] d); cyc(1'b0, 9'h0, 1'b1, 1'b0, 1'b0, 1'b0, d, 1'b0, 1'b0); endtask
    task automatic rxo();         cyc(1'b0, 9'h0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0); endtask
    task automatic txp(input logic [7:0] d); cyc(1'b0, 9'h0, 1'b0, 1'b0, 1'b1, 1'b0, d, 1'b0, 1'b0); endtask
    task automatic txo();         cyc(1'b0, 9'h0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0, 1'b0, 1'b0); endtask
    task automatic wcfg(input logic [8:0] w); cyc(1'b1, w, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b0); endtask
    task automatic tick(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 9'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b1, 1'b0);
    endtask
    task automatic clr();         cyc(1'b0, 9'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b0, 1'b1); endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle();
        // R12 reset state
        chk("R12 rx_count", rx_count, 0);
        chk("R12 tx_count", tx_count, 0);
        chk("R12 cfg_rdata", cfg_rdata, 0);
        chk("R12 rx_timeout", rx_timeout, 0);
        chk("R12 rx_req", rx_req, 0);
        chk("R12 tx_req", tx_req, 1);

        for (int i = 0; i < 14; i++) begin
            cyc(TBL[i].we, TBL[i].wd, TBL[i].rxp, TBL[i].rxo, TBL[i].txp,
                TBL[i].txo, TBL[i].d, 1'b0, 1'b0);
            chk("R5 rx_count", rx_count, TBL[i].erx);
            chk("R5 tx_count", tx_count, TBL[i].etx);
            chk("R4 rx_req", rx_req, TBL[i].erq);
            chk("R3 tx_req", tx_req, TBL[i].etq);
        end
        chk("R1 readback", cfg_rdata, 9'h089);

        // R5 order, full drop, empty pop
        tmo_en = 1'b0;
        for (int i = 0; i < 17; i++) rxp(8'h10 + 8'(i));
        chk("R5 full count", rx_count, 16);
        chk("R5 head", rx_dout, 8'h10);
        rxo();
        chk("R5 second", rx_dout, 8'h11);
        wcfg(9'h08B);
        rxo();
        chk("R5 empty pop count", rx_count, 0);
        chk("R5 empty dout", rx_dout, 0);

        // R4 nonzero with timeout disabled
        rxp(8'h55);
        chk("R4 nonzero no tmo", rx_req, 1);
        wcfg(9'h08B);

        // R6 single holding register
        wcfg(9'h000);
        rxp(8'hC1);
        chk("R6 rx_count", rx_count, 1);
        chk("R6 rx_req", rx_req, 1);
        rxp(8'hC2);
        chk("R6 ignored push count", rx_count, 1);
        chk("R6 held byte", rx_dout, 8'hC1);
        // R11 DMA busy
        rx_mode = 2'd2;
        #1 chk("R11 busy with data", dma_busy, 0);
        rxo();
        chk("R6 rx_req after read", rx_req, 0);
        chk("R11 busy empty", dma_busy, 1);
        rx_mode = 2'd0;
        #1 chk("R11 other mode", dma_busy, 0);
        txp(8'hD1);
        chk("R6 tx_req held", tx_req, 0);
        txp(8'hD2);
        chk("R6 tx ignored push", tx_count, 1);
        chk("R6 tx byte", tx_dout, 8'hD1);
        txo();
        chk("R3 tx_req single empty", tx_req, 1);

        // R7 timer expiry after three characters
        wcfg(9'h089);
        tmo_en = 1'b1; tmo_chars = 4'd3;
        rxp(8'hE1);
        tick(2);
        chk("R7 before expiry", rx_timeout, 0);
        tick(1);
        chk("R9 expiry with data", rx_timeout, 1);
        chk("R4 rx_req from timeout", rx_req, 1);
        clr();
        chk("R10 clear", rx_timeout, 0);
        chk("R4 rx_req after clear", rx_req, 0);

        // R7 restart on a new byte
        rxp(8'hE2);
        tick(2);
        rxp(8'hE3);
        tick(2);
        chk("R7 restarted", rx_timeout, 0);
        tick(1);
        chk("R7 expiry after restart", rx_timeout, 1);
        clr();

        // R10 set wins over clear
        tmo_chars = 4'd1;
        rxo();
        rxp(8'hE4);
        cyc(1'b0, 9'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0, 1'b1, 1'b1);
        chk("R10 set wins", rx_timeout, 1);
        clr();
        chk("R10 cleared", rx_timeout, 0);

        // R8 halt by level
        tmo_chars = 4'd3;
        rxp(8'hE5);
        tick(4);
        chk("R8 halted by level", rx_timeout, 0);
        rxo();
        tick(4);
        chk("R8 stays halted", rx_timeout, 0);
        chk("R4 below level", rx_req, 0);

        // R8 halt by disable
        wcfg(9'h08B);
        rxp(8'hE6);
        tmo_en = 1'b0;
        idle();
        tmo_en = 1'b1;
        tick(4);
        chk("R8 halted by disable", rx_timeout, 0);

        // R9 expiry with empty FIFO, force low then high
        rxo();
        rxp(8'hE7);
        rxo();
        tick(3);
        chk("R9 empty no force", rx_timeout, 0);
        rxp(8'hE8);
        rxo();
        tmo_force = 1'b1;
        tick(3);
        chk("R9 empty forced", rx_timeout, 1);
        clr();
        tmo_force = 1'b0;

        // R7 zero length fires on first tick
        tmo_chars = 4'd0;
        rxp(8'hE9);
        tick(1);
        chk("R7 zero length", rx_timeout, 1);
        clr();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule